// File: doc/BRIEF.md
# Timed Toggle Event Player

This block plays back a precomputed schedule of pin toggles. A producer writes event records into an on-chip ring of 64 records. A playback engine takes them out one at a time. Each record carries a 12-bit toggle mask and a delay code. When a record is applied, its mask is XORed into a 12-bit output register. The engine then holds that state for a whole number of 20-clock ticks before it applies the next record.

The intended use is square-wave generation from a schedule. Software or a companion engine computes when each of twelve outputs must flip, and this block turns that list into edges that are exact to the clock. Playback starts after a fixed lead time, which gives the producer a chance to fill the ring before the first record is needed.

Top module: `toggle_event_player`

## Requirements
- R1: While reset is asserted, `tone_out` is all zero, `ring_full` is 0 and `underflow` is 0.
- R2: A written record is 32 bits wide. Bits [7:0] toggle outputs 0 to 7 and bits [11:8] toggle outputs 8 to 11. Applying a record XORs this 12-bit mask into `tone_out`, so each set bit flips its pin.
- R3: Bits [15:12] and [31:24] of a record have no effect on the outputs or on the timing.
- R4: The first record is applied at the 2048th rising clock edge after reset is released. Until then `tone_out` stays zero.
- R5: Bits [23:16] of a record hold a delay code d. The next record is applied exactly (d+1)*20 clocks after that record, and the outputs hold their value in between. This holds for every code from 0 to 255.
- R6: Records with delay code 0 are applied exactly 20 clocks apart, with no jitter, even while the producer writes on every cycle.
- R7: The ring holds at most 63 records. `ring_full` is 1 exactly when 63 records are waiting. A write attempted while `ring_full` is 1 is dropped.
- R8: Records are applied in the order they were accepted, and the read and write positions wrap around the 64-entry ring.
- R9: If no record is waiting when one is due, `tone_out` holds its value, `underflow` becomes 1, and the engine tries again one tick (20 clocks) later.
- R10: Once set, `underflow` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset. Asserts asynchronously; assumed to be released in step with `clk` |
| wr_en | input | 1 | Write strobe for one record |
| wr_record | input | 32 | Record to write: mask low byte, mask high nibble, delay code, pad |
| ring_full | output | 1 | Ring holds 63 records; further writes are dropped |
| tone_out | output | 12 | Toggled output pins |
| underflow | output | 1 | Sticky flag: a record was due while the ring was empty |

## Verification
The first pattern fills the ring ahead of the lead time with 64 write attempts. The delay codes are mixed: small ones, 9, and the maximum of 255. The masks are walking and scrambled, and the ignored bits are nonzero. This pattern separates correct mask bit placement, correct per-code dwell time and the dropping of the write made while the ring is full. The ring is then left to run dry, which shows whether the engine holds the outputs and retries on tick boundaries. The second pattern streams delay-0 records on every cycle past the wrap point. This shows whether spacing stays at exactly 20 clocks while writes and reads overlap, and whether order is kept across the wrap. The outputs are compared with an arithmetic model on every cycle, so an edge that comes one clock early or late is caught.

// File: rtl/tep_pkg.sv
package tep_pkg;
  localparam int TEP_PINS  = 12;
  localparam int TEP_DLY_W = 8;

  // Event as kept in the ring: only the fields that matter to playback.
  typedef struct packed {
    logic [TEP_DLY_W-1:0] dly;
    logic [TEP_PINS-1:0]  mask;
  } tep_evt_t;

  localparam int TEP_EVT_W = TEP_DLY_W + TEP_PINS;
endpackage

// File: rtl/tep_ring.sv
module tep_ring
  import tep_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  tep_evt_t push_evt,
  input  logic     pop,
  output tep_evt_t head_evt,
  output logic     full,
  output logic     empty
);
  localparam int AW = $clog2(DEPTH);

  tep_evt_t       mem [DEPTH];
  logic [AW-1:0]  wr_ptr, wr_ptr_nxt;
  logic [AW-1:0]  rd_ptr, rd_ptr_nxt;
  logic           wr_go, rd_go;

  // Full leaves one slot unused so that equal pointers always mean empty.
  assign full  = (wr_ptr + AW'(1)) == rd_ptr;
  assign empty = wr_ptr == rd_ptr;
  assign wr_go = push && !full;
  assign rd_go = pop && !empty;
  assign head_evt = mem[rd_ptr];

  always_comb begin
    wr_ptr_nxt = wr_ptr;
    rd_ptr_nxt = rd_ptr;
    if (wr_go) wr_ptr_nxt = wr_ptr + AW'(1);   // wraps naturally (R8)
    if (rd_go) rd_ptr_nxt = rd_ptr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
    end
  end

  // Storage is not reset; it is only read once it has been written.
  always_ff @(posedge clk) begin
    if (wr_go) mem[wr_ptr] <= push_evt;
  end

  assert_full_drops_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (wr_ptr == $past(wr_ptr)));

  assert_empty_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> (rd_ptr == $past(rd_ptr)));

  assert_read_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_ptr == $past(rd_ptr) || rd_ptr == $past(rd_ptr) + AW'(1)));
endmodule

// File: rtl/tep_tick.sv
module tep_tick #(
  parameter int TICK_CLKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);
  localparam int TW = $clog2(TICK_CLKS);

  logic [TW-1:0] cnt, cnt_nxt;

  assign tick = en && (cnt == TW'(TICK_CLKS - 1));

  always_comb begin
    cnt_nxt = cnt;
    if (clr)       cnt_nxt = '0;   // realign on every applied event (R6)
    else if (tick) cnt_nxt = '0;
    else if (en)   cnt_nxt = cnt + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tep_sched.sv
module tep_sched
  import tep_pkg::*;
#(
  parameter int LEAD_CLKS = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ring_empty,
  input  tep_evt_t            head_evt,
  output logic                fire,
  output logic                pop,
  output logic                running,
  output logic [TEP_PINS-1:0] pins,
  output logic                underflow
);
  localparam int LW = $clog2(LEAD_CLKS);

  logic [LW-1:0]        lead_cnt, lead_cnt_nxt;
  logic [TEP_DLY_W-1:0] dly_cnt, dly_cnt_nxt;
  logic [TEP_PINS-1:0]  pins_nxt;
  logic                 running_nxt, underflow_nxt;

  // An event is due either at the end of the lead time (R4) or when the
  // delay counter is spent at a tick boundary (R5).
  assign fire = running ? (tick && dly_cnt == '0)
                        : (lead_cnt == LW'(LEAD_CLKS - 1));
  assign pop  = fire && !ring_empty;

  always_comb begin
    lead_cnt_nxt  = lead_cnt;
    dly_cnt_nxt   = dly_cnt;
    pins_nxt      = pins;
    running_nxt   = running || fire;
    underflow_nxt = underflow || (fire && ring_empty);  // sticky (R10)
    if (!running) lead_cnt_nxt = lead_cnt + LW'(1);
    if (fire) begin
      if (ring_empty) begin
        dly_cnt_nxt = '0;                        // retry next tick (R9)
      end else begin
        pins_nxt    = pins ^ head_evt.mask;      // R2
        dly_cnt_nxt = head_evt.dly;
      end
    end else if (tick && dly_cnt != '0) begin
      dly_cnt_nxt = dly_cnt - TEP_DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_cnt  <= '0;
      dly_cnt   <= '0;
      pins      <= '0;
      running   <= 1'b0;
      underflow <= 1'b0;
    end else begin
      lead_cnt  <= lead_cnt_nxt;
      dly_cnt   <= dly_cnt_nxt;
      pins      <= pins_nxt;
      running   <= running_nxt;
      underflow <= underflow_nxt;
    end
  end

  assert_quiet_before_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pins == '0));

  assert_hold_on_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ring_empty) |=> $stable(pins));

  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_pins_only_on_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> $stable(pins));
endmodule

// File: rtl/toggle_event_player.sv
module toggle_event_player
  import tep_pkg::*;
#(
  parameter int RING_RECS = 64,
  parameter int TICK_CLKS = 20,
  parameter int LEAD_CLKS = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [31:0]         wr_record,
  output logic                ring_full,
  output logic [TEP_PINS-1:0] tone_out,
  output logic                underflow
);
  tep_evt_t wr_evt, head_evt;
  logic     ring_empty, fire, pop, running, tick;
  logic     unused_rec_bits;

  // Record layout: [7:0] mask low, [11:8] mask high, [23:16] delay code.
  // Bits [15:12] and [31:24] are padding and are dropped here (R3).
  assign wr_evt.mask     = wr_record[11:0];
  assign wr_evt.dly      = wr_record[23:16];
  assign unused_rec_bits = ^{wr_record[31:24], wr_record[15:12]};

  tep_ring #(.DEPTH(RING_RECS)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_en),
    .push_evt (wr_evt),
    .pop      (pop),
    .head_evt (head_evt),
    .full     (ring_full),
    .empty    (ring_empty)
  );

  tep_tick #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (running),
    .clr   (fire),
    .tick  (tick)
  );

  tep_sched #(.LEAD_CLKS(LEAD_CLKS)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .ring_empty (ring_empty),
    .head_evt   (head_evt),
    .fire       (fire),
    .pop        (pop),
    .running    (running),
    .pins       (tone_out),
    .underflow  (underflow)
  );
endmodule

// File: tb/toggle_event_player_bench.sv
`timescale 1ns/1ps
module toggle_event_player_bench;
  localparam int LEAD = 2048;
  localparam int TICK = 20;
  localparam int CAP  = 63;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_record;
  logic        ring_full;
  logic [11:0] tone_out;
  logic        underflow;

  int checks = 0, errors = 0;
  int cyc = 0, next_edge = LEAD;
  logic [31:0] q [256];
  int qh = 0, qt = 0, qn = 0;
  logic [11:0] m_pins = '0;
  bit m_under = 0;
  bit phase2 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  toggle_event_player u_toggle_event_player (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_record(wr_record),
    .ring_full(ring_full), .tone_out(tone_out), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual 0x%0h expected 0x%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [31:0] d);
    bit acc, was_under;
    string tag;
    logic [31:0] r;
    acc = we && (qn < CAP);               // R7: a write while full is dropped
    wr_en = we;
    wr_record = d;
    @(posedge clk);
    @(negedge clk);
    cyc++;
    was_under = m_under;
    tag = (cyc < LEAD) ? "R4" : "R5";
    if (cyc == next_edge) begin
      if (qn > 0) begin
        r = q[qh]; qh = (qh + 1) % 256; qn--;
        m_pins ^= {r[11:8], r[7:0]};
        next_edge += (int'(r[23:16]) + 1) * TICK;
        if (phase2) tag = "R6/R8";
        else if (r[11:0] == 12'h0) tag = "R3";
        else tag = "R2";
      end else begin
        m_under = 1;
        next_edge += TICK;
        tag = "R9";
      end
    end
    if (acc) begin q[qt] = d; qt = (qt + 1) % 256; qn++; end
    chk(tone_out === m_pins, tag, int'(tone_out), int'(m_pins));
    chk(underflow === m_under, was_under ? "R10" : "R9", int'(underflow), int'(m_under));
    chk(ring_full === (qn == CAP), "R7", int'(ring_full), int'(qn == CAP));
  endtask

  function automatic logic [31:0] rec1(input int i);
    logic [7:0] lo, hi, dl, pad;
    lo  = 8'(i * 37 + 1) ^ (8'h1 << (i % 8));
    hi  = {4'(i * 3 + 5), 4'(i * 5 + 1)};
    dl  = (i % 5 == 4) ? 8'd9 : 8'(i % 4);
    if (i == 10) dl = 8'd255;
    pad = 8'(i) ^ 8'h5A;
    if (i == 20) begin lo = 8'h00; hi = 8'hF0; pad = 8'hFF; end   // R3 record
    return {pad, dl, hi, lo};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_record = '0;
    repeat (3) @(negedge clk);
    chk(tone_out === 12'h0, "R1", int'(tone_out), 0);
    chk(ring_full === 1'b0, "R1", int'(ring_full), 0);
    chk(underflow === 1'b0, "R1", int'(underflow), 0);
    rst_n = 1'b1;
    // Phase 1: 64 attempts, the last is dropped because 63 are waiting (R7).
    for (int i = 0; i < 64; i++) step(1'b1, rec1(i));
    chk(ring_full === 1'b1, "R7", int'(ring_full), 1);
    // Drain, then run dry to exercise hold and retry (R9, R10).
    while ((qn > 0 || !m_under) && cyc < 150000) step(1'b0, 32'h0);
    repeat (50) step(1'b0, 32'h0);
    // Phase 2: back-to-back delay-0 records past the wrap point (R6, R8).
    phase2 = 1;
    for (int i = 0; i < 80; i++)
      step(1'b1, {8'hC3, 8'h00, 8'(4'(i) << 4) | 8'(i % 16), 8'(i * 29 + 3)});
    while (qn > 0 && cyc < 150000) step(1'b0, 32'h0);
    repeat (45) step(1'b0, 32'h0);
    chk(underflow === 1'b1, "R10", int'(underflow), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule